// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block produces the start-up command stream for up to two external SDRAM devices. The devices share the row, column, write and address pins, and each has its own chip select. A single-cycle start pulse latches the configuration and raises the memory clock enable. After a power-up wait, the block issues one precharge-all command, a programmable burst of auto-refresh commands, and one load-mode-register command that carries a 14-bit mode word on the address lines. Every command is aimed at the devices marked present. A no-operation is driven on every cycle between commands, and each gap between commands is a programmable cycle count.

The power-up wait is given in microseconds. The block turns it into clock cycles with a clocks-per-microsecond parameter. When the last command's recovery time has passed, `done` rises and stays high until reset. The refresh logic that runs after start-up can use this flag to begin its period.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is applied and on the cycle after it, `sd_cke`=0, `sd_cs_n`=all ones, `sd_ras_n`/`sd_cas_n`/`sd_we_n`=1, `sd_addr`=0, `busy`=0 and `done`=0. Synchronous active-high reset.
- R2: A start pulse sampled while idle (not busy, not done) raises `sd_cke` and `busy` at that same edge. On every cycle from then on that carries no command, the pins show a no-operation: `sd_ras_n`,`sd_cas_n`,`sd_we_n` = 1,1,1 and `sd_addr`=0.
- R3: The precharge-all command (ras_n,cas_n,we_n = 0,1,0, address bit 10 = 1, every other address bit 0) appears N = max(1, `cfg_pwr_us`·CLK_PER_US) cycles after the edge that raised `sd_cke`.
- R4: Exactly `cfg_nref` auto-refresh commands (ras_n,cas_n,we_n = 0,0,1, address 0) follow. The first comes max(1,`cfg_trp`) cycles after the precharge, and the rest are spaced max(1,`cfg_trc`) cycles apart. A count of 0 issues none.
- R5: The load-mode-register command (ras_n,cas_n,we_n = 0,0,0, `sd_addr[13:0]` = mode word) comes max(1,`cfg_trc`) cycles after the last refresh, or max(1,`cfg_trp`) cycles after the precharge when no refresh is issued.
- R6: `busy` stays high and `done` stays low until max(1,`cfg_tmrd`) cycles after the load-mode command. From that edge on, `done`=1 and `busy`=0 until reset.
- R7: From the start edge on, `sd_cs_n[i]` is low exactly when bit i of `cfg_bank_en` was set at start (bit 0 = first device, bit 1 = second device, both when 11).
- R8: A start pulse while busy or done has no effect, and configuration inputs changed after the start edge do not alter the command stream.
- R9: Once raised, `sd_cke` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cfg_bank_en | input | 2 | Devices present (bit 0 first, bit 1 second) |
| cfg_pwr_us | input | PWR_W (16) | Power-up wait in microseconds |
| cfg_nref | input | REF_W (4) | Number of auto-refresh commands |
| cfg_mode | input | 14 | Mode word for the load-mode command |
| cfg_trp | input | GAP_W (4) | Cycles after precharge |
| cfg_trc | input | GAP_W (4) | Cycles after each refresh |
| cfg_tmrd | input | GAP_W (4) | Cycles after load-mode |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 2 | Active-low chip selects |
| sd_ras_n | output | 1 | Active-low row strobe |
| sd_cas_n | output | 1 | Active-low column strobe |
| sd_we_n | output | 1 | Active-low write enable |
| sd_addr | output | ADDR_W (14) | Address lines |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, sticky until reset |

## Verification
The bench builds the block with CLK_PER_US=4 and leaves the other parameters at their defaults. This keeps the default 100-microsecond wait at 400 cycles, so the full-length power-up path can be run cycle by cycle. The 4-bit gap and count widths let the bench cover zero gaps (which clamp to one cycle), a zero refresh count, one-cycle spacing and the all-ones maximum of 15. The 14-bit mode field is exercised with alternating and all-ones patterns.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

    localparam int NDEV    = 2;   // chip selects
    localparam int MODE_W  = 14;  // mode word width
    localparam int A10_BIT = 10;  // precharge-all flag position

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PALL,
        CMD_REF,
        CMD_LMR
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_REF,
        ST_MRD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic cmd_pins_t encode_cmd(cmd_e c);
        cmd_pins_t p;
        case (c)
            CMD_PALL: p = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF:  p = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LMR:  p = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:  p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdram_init_gap_timer.sv
`timescale 1ns/1ps
module sdram_init_gap_timer #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] remain_q;

    // A gap of len cycles (minimum one) until the next issue edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= (len == '0) ? '0 : len - 1'b1;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
`timescale 1ns/1ps
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int PWR_W      = 16,
    parameter int REF_W      = 4,
    parameter int GAP_W      = 4,
    parameter int CNT_W      = 23
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [NDEV-1:0]        cfg_bank_en,
    input  logic [PWR_W-1:0]       cfg_pwr_us,
    input  logic [REF_W-1:0]       cfg_nref,
    input  logic [MODE_W-1:0]      cfg_mode,
    input  logic [GAP_W-1:0]       cfg_trp,
    input  logic [GAP_W-1:0]       cfg_trc,
    input  logic [GAP_W-1:0]       cfg_tmrd,
    input  logic                   expired,
    output cmd_e                   cmd,
    output logic [NDEV-1:0]        tgt,
    output logic [MODE_W-1:0]      mode,
    output logic                   cke_req,
    output logic                   load,
    output logic [CNT_W-1:0]       load_len,
    output logic                   busy,
    output logic                   done
);
    seq_state_e        state_q;
    logic [NDEV-1:0]   tgt_q;
    logic [REF_W-1:0]  nref_q;
    logic [REF_W-1:0]  ref_left_q;
    logic [MODE_W-1:0] mode_q;
    logic [GAP_W-1:0]  trp_q;
    logic [GAP_W-1:0]  trc_q;
    logic [GAP_W-1:0]  tmrd_q;
    logic [CNT_W-1:0]  pwr_cycles;

    assign pwr_cycles = CNT_W'(cfg_pwr_us) * CNT_W'(CLK_PER_US);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            tgt_q      <= '0;
            nref_q     <= '0;
            ref_left_q <= '0;
            mode_q     <= '0;
            trp_q      <= '0;
            trc_q      <= '0;
            tmrd_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    tgt_q   <= cfg_bank_en;
                    nref_q  <= cfg_nref;
                    mode_q  <= cfg_mode;
                    trp_q   <= cfg_trp;
                    trc_q   <= cfg_trc;
                    tmrd_q  <= cfg_tmrd;
                    state_q <= ST_PWR;
                end
                ST_PWR: if (expired) begin
                    ref_left_q <= nref_q;
                    state_q    <= ST_REF;
                end
                ST_REF: if (expired) begin
                    if (ref_left_q != '0) ref_left_q <= ref_left_q - 1'b1;
                    else                  state_q    <= ST_MRD;
                end
                ST_MRD: if (expired) state_q <= ST_DONE;
                default: state_q <= state_q;
            endcase
        end
    end

    always_comb begin
        cmd      = CMD_NOP;
        load     = 1'b0;
        load_len = '0;
        cke_req  = 1'b1;
        case (state_q)
            ST_IDLE: begin
                cmd     = start ? CMD_NOP : CMD_DESEL;
                cke_req = start;
                if (start) begin
                    load     = 1'b1;
                    load_len = pwr_cycles;
                end
            end
            ST_PWR: if (expired) begin
                cmd      = CMD_PALL;
                load     = 1'b1;
                load_len = CNT_W'(trp_q);
            end
            ST_REF: if (expired) begin
                load = 1'b1;
                if (ref_left_q != '0) begin
                    cmd      = CMD_REF;
                    load_len = CNT_W'(trc_q);
                end else begin
                    cmd      = CMD_LMR;
                    load_len = CNT_W'(tmrd_q);
                end
            end
            default: ;
        endcase
    end

    assign tgt  = (state_q == ST_IDLE) ? cfg_bank_en : tgt_q;
    assign mode = mode_q;
    assign busy = (state_q == ST_PWR) || (state_q == ST_REF) || (state_q == ST_MRD);
    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_init_pin_reg.sv
`timescale 1ns/1ps
module sdram_init_pin_reg
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [NDEV-1:0]   tgt,
    input  logic [MODE_W-1:0] mode,
    input  logic              cke_req,
    output logic              sd_cke,
    output logic [NDEV-1:0]   sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr
);
    cmd_pins_t         pins_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        pins_d = encode_cmd(cmd);
        addr_d = '0;
        if (cmd == CMD_PALL) addr_d[A10_BIT] = 1'b1;
        if (cmd == CMD_LMR)  addr_d = ADDR_W'(mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_cke   <= 1'b0;
            sd_ras_n <= 1'b1;
            sd_cas_n <= 1'b1;
            sd_we_n  <= 1'b1;
            sd_addr  <= '0;
        end else begin
            sd_cke   <= cke_req;
            sd_ras_n <= pins_d.ras_n;
            sd_cas_n <= pins_d.cas_n;
            sd_we_n  <= pins_d.we_n;
            sd_addr  <= addr_d;
        end
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_cs
        always_ff @(posedge clk) begin
            if (rst) sd_cs_n[d] <= 1'b1;
            else     sd_cs_n[d] <= (cmd == CMD_DESEL) ? 1'b1 : ~tgt[d];
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int PWR_W      = 16,
    parameter int REF_W      = 4,
    parameter int GAP_W      = 4,
    parameter int ADDR_W     = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         cfg_bank_en,
    input  logic [PWR_W-1:0]   cfg_pwr_us,
    input  logic [REF_W-1:0]   cfg_nref,
    input  logic [13:0]        cfg_mode,
    input  logic [GAP_W-1:0]   cfg_trp,
    input  logic [GAP_W-1:0]   cfg_trc,
    input  logic [GAP_W-1:0]   cfg_tmrd,
    output logic               sd_cke,
    output logic [1:0]         sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [ADDR_W-1:0]  sd_addr,
    output logic               busy,
    output logic               done
);
    localparam int CPU_W  = $clog2(CLK_PER_US + 1);
    localparam int CNT_W0 = PWR_W + CPU_W;
    localparam int CNT_W  = (CNT_W0 > GAP_W) ? CNT_W0 : GAP_W;

    cmd_e              cmd;
    logic [NDEV-1:0]   tgt;
    logic [MODE_W-1:0] mode;
    logic              cke_req;
    logic              load;
    logic [CNT_W-1:0]  load_len;
    logic              expired;

    sdram_init_fsm #(
        .CLK_PER_US (CLK_PER_US),
        .PWR_W      (PWR_W),
        .REF_W      (REF_W),
        .GAP_W      (GAP_W),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cfg_bank_en (cfg_bank_en),
        .cfg_pwr_us  (cfg_pwr_us),
        .cfg_nref    (cfg_nref),
        .cfg_mode    (cfg_mode),
        .cfg_trp     (cfg_trp),
        .cfg_trc     (cfg_trc),
        .cfg_tmrd    (cfg_tmrd),
        .expired     (expired),
        .cmd         (cmd),
        .tgt         (tgt),
        .mode        (mode),
        .cke_req     (cke_req),
        .load        (load),
        .load_len    (load_len),
        .busy        (busy),
        .done        (done)
    );

    sdram_init_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .len     (load_len),
        .expired (expired)
    );

    sdram_init_pin_reg #(.ADDR_W(ADDR_W)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .tgt      (tgt),
        .mode     (mode),
        .cke_req  (cke_req),
        .sd_cke   (sd_cke),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_addr  (sd_addr)
    );

endmodule

// File: rtl/sdram_init_chk.sv
`timescale 1ns/1ps
module sdram_init_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              sd_cke,
    input logic [1:0]        sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              busy,
    input logic              done
);
    logic is_pall, is_ref, selected;
    assign selected = !(&sd_cs_n);
    assign is_pall  = selected && !sd_ras_n &&  sd_cas_n && !sd_we_n;
    assign is_ref   = selected && !sd_ras_n && !sd_cas_n &&  sd_we_n;

    a_r1_off_is_deselect: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> (&sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));

    a_r2_start_raises: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> (busy && sd_cke));

    a_r3_pall_a10: assert property (@(posedge clk) disable iff (rst)
        is_pall |-> sd_addr[10]);

    a_r4_ref_addr_zero: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (sd_addr == '0));

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    a_r8_start_after_done: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (done && !busy));

    a_r9_cke_holds: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke);

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
    localparam int CPU = 4;

    typedef struct packed {
        logic [1:0]  banks;
        logic [15:0] pwr;
        logic [3:0]  nref;
        logic [13:0] mode;
        logic [3:0]  trp;
        logic [3:0]  trc;
        logic [3:0]  tmrd;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'b01, 16'd2,   4'd8,  14'h0220, 4'd2,  4'd6,  4'd2},
        '{2'b10, 16'd1,   4'd1,  14'h3FFF, 4'd3,  4'd4,  4'd3},
        '{2'b11, 16'd0,   4'd0,  14'h1555, 4'd0,  4'd0,  4'd0},
        '{2'b11, 16'd100, 4'd15, 14'h2AAA, 4'd15, 4'd15, 4'd15},
        '{2'b01, 16'd3,   4'd2,  14'h0031, 4'd1,  4'd1,  4'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cfg_bank_en = '0;
    logic [15:0] cfg_pwr_us = '0;
    logic [3:0]  cfg_nref = '0;
    logic [13:0] cfg_mode = '0;
    logic [3:0]  cfg_trp = '0, cfg_trc = '0, cfg_tmrd = '0;
    logic        sd_cke, sd_ras_n, sd_cas_n, sd_we_n, busy, done;
    logic [1:0]  sd_cs_n;
    logic [13:0] sd_addr;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(.CLK_PER_US(CPU)) dut (
        .clk(clk), .rst(rst), .start(start), .cfg_bank_en(cfg_bank_en),
        .cfg_pwr_us(cfg_pwr_us), .cfg_nref(cfg_nref), .cfg_mode(cfg_mode),
        .cfg_trp(cfg_trp), .cfg_trc(cfg_trc), .cfg_tmrd(cfg_tmrd),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int g1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic logic [16:0] pins_now();
        return {sd_ras_n, sd_cas_n, sd_we_n, sd_addr};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_case(input vec_t v, input bit disturb);
        int p, l, d, first_ref;
        logic [16:0] exp;
        string tag;
        p = g1(int'(v.pwr) * CPU);
        first_ref = p + g1(int'(v.trp));
        l = first_ref + int'(v.nref) * g1(int'(v.trc));
        d = l + g1(int'(v.tmrd));
        cfg_bank_en = v.banks; cfg_pwr_us = v.pwr; cfg_nref = v.nref;
        cfg_mode = v.mode; cfg_trp = v.trp; cfg_trc = v.trc; cfg_tmrd = v.tmrd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sd_cke && busy, "R2", {30'd0, sd_cke, busy}, 32'd3);
        for (int c = 1; c <= d + 3; c++) begin
            if (disturb && c == 3) begin
                cfg_mode = ~v.mode; cfg_nref = 4'd1; cfg_trc = 4'd1; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (c == p) begin
                exp = {3'b010, 14'h0400}; tag = "R3";
            end else if (c == l) begin
                exp = {3'b000, v.mode}; tag = "R5";
            end else if (v.nref != 0 && c >= first_ref && c < l &&
                         ((c - first_ref) % g1(int'(v.trc))) == 0) begin
                exp = {3'b001, 14'h0}; tag = "R4";
            end else begin
                exp = {3'b111, 14'h0}; tag = "R2";
            end
            if (disturb) tag = "R8";
            chk(pins_now() == exp, tag, 32'(pins_now()), 32'(exp));
            chk(sd_cs_n == ~v.banks, "R7", 32'(sd_cs_n), 32'(~v.banks));
            chk(sd_cke == 1'b1, "R9", 32'(sd_cke), 32'd1);
            chk({busy, done} == ((c < d) ? 2'b10 : 2'b01), "R6",
                32'({busy, done}), 32'((c < d) ? 2'b10 : 2'b01));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(!sd_cke, "R1", 32'(sd_cke), 0);
        chk(sd_cs_n == 2'b11, "R1", 32'(sd_cs_n), 3);
        chk(pins_now() == {3'b111, 14'h0}, "R1", 32'(pins_now()), 32'h1C000);
        chk({busy, done} == 2'b00, "R1", 32'({busy, done}), 0);
        rst = 1'b0;
        // R2: no start keeps the pins deselected
        repeat (5) @(negedge clk);
        chk(!sd_cke && sd_cs_n == 2'b11 && !busy, "R2", {29'd0, sd_cke, sd_cs_n}, 3);

        // Vector table walk
        for (int i = 0; i < 5; i++) begin
            do_reset();
            run_case(VECS[i], 1'b0);
        end

        // R8: start after done is ignored
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk(pins_now() == {3'b111, 14'h0} && done && !busy, "R8",
                32'(pins_now()), 32'h1C000);
            @(negedge clk);
        end

        // R8: start while busy and config changes after start
        do_reset();
        begin
            int b0;
            b0 = bad;
            run_case(VECS[0], 1'b1);
            chk(bad == b0, "R8", 32'(bad - b0), 0);
        end

        // R1: reset in the middle of a sequence
        do_reset();
        cfg_bank_en = 2'b11; cfg_pwr_us = 16'd5; cfg_nref = 4'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!sd_cke && sd_cs_n == 2'b11 && !busy && !done, "R1",
            {28'd0, sd_cke, sd_cs_n, busy}, 32'h6);
        chk(pins_now() == {3'b111, 14'h0}, "R1", 32'(pins_now()), 32'h1C000);
        rst = 1'b0;
        @(negedge clk);
        chk(!sd_cke && !busy, "R9", 32'(sd_cke), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule